// File: doc/BRIEF.md
# Protected System Configuration Register File

This block is a small system-control register file sitting on a 32-bit word-addressed register bus. It holds a device-configuration word whose bits drive pin-mux and peripheral-enable lines, an audio clock-divider word, a lock word and a read-only identification word that carries a chip revision field. The device-configuration and audio-divider words are protected. Software must first write an unlock key to the lock word, and the key allows exactly one following bus write to reach a protected word.

Software updates device configuration by read-modify-write. It reads the word, clears and sets the bits it wants, writes the key and then writes the result back. The block decodes three control functions from the word. Clearing a software-reset bit after it has been set produces a one-cycle reset request for the chip's reset controller. Two audio-routing bits steer the serial audio interface onto one of two pin groups, and the block never drives both routes at the same time. Reset generation and the pin multiplexers themselves live outside the block.

Top module: `syscfg_regs`

## Requirements
- R1: After reset the block is not armed (lock word reads 0), device configuration equals DEVCFG_DFLT (default 0: every peripheral enable clear, all pins general-purpose I/O), the audio divider is 0 and rst_req_o is low.
- R2: A bus write to word 0 (lock) whose low byte is 0xAA arms the block. While armed, a read of word 0 returns 1; otherwise it returns 0.
- R3: A write to word 1 (device configuration) or word 2 (audio divider) while armed stores bus_wdata, which is readable on the next cycle.
- R4: A write to word 1 or word 2 while not armed is ignored and the stored value does not change.
- R5: The armed state is cleared by the next bus write of any kind, including writes to word 3, to unmapped words and non-key writes to word 0, so one key enables only one protected write. Reads do not disarm.
- R6: Word 3 is read-only and reads SYSID_BASE with the revision REV_VAL in bits [REV_LSB +: REV_W] (default: bits 31:28 = 5, so the word reads 0x5000_0000). Writes to it have no effect.
- R7: rst_req_o goes high for exactly one cycle when device-configuration bit SWRST_BIT (default 31) changes from 1 to 0. Setting the bit gives no pulse.
- R8: Device-configuration bit SSP_BIT (default 6) requests the SSP-pin audio route and bit AC97_BIT (default 7) requests the AC97-pin audio route. route_ssp_o and route_ac97_o are never both high. With EXCL_ROUTE=1 (default), both routes are off when both bits are set.
- R9: devcfg_o and auddiv_o always present the stored protected words.
- R10: A read of an unmapped word (4 and above) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| devcfg_o | output | DATA_W | Device-configuration word to pin-mux logic |
| auddiv_o | output | DATA_W | Audio clock-divider word |
| rst_req_o | output | 1 | One-cycle software reset request |
| route_ssp_o | output | 1 | Audio interface routed to SSP pins |
| route_ac97_o | output | 1 | Audio interface routed to AC97 pins |

## Verification
The bound checker checks the following on every cycle: a key write arms the block, any other write disarms it, an unarmed write leaves both protected words unchanged, an armed write lands exactly, the lock readback matches the armed state, the reset request never lasts two cycles and the two audio routes are never both active. Some behaviour is visible only through the bench's ordered scenarios. These cover the one-shot use of a key across writes to the lock, identification and unmapped words; the read-modify-write routing changes; the set-then-clear reset sequence with its pulse count; and the extraction of the revision field by mask and shift.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
   localparam int          IDX_LOCK   = 0;
   localparam int          IDX_DEVCFG = 1;
   localparam int          IDX_AUDDIV = 2;
   localparam int          IDX_SYSID  = 3;
   localparam int          NPROT      = 2;
   localparam logic [7:0]  UNLOCK_KEY = 8'hAA;

   typedef enum logic [1:0] {
      PSEL_DEVCFG = 2'd0,
      PSEL_AUDDIV = 2'd1
   } prot_sel_e;
endpackage

// File: rtl/syscfg_lock.sv
module syscfg_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic any_we,
   input  logic key_hit,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (any_we) armed <= key_hit;
   end
endmodule

// File: rtl/syscfg_preg.sv
module syscfg_preg #(
   parameter int              W   = 32,
   parameter logic [W-1:0]    RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST;
      else if (wr_en) q <= wdata;
   end
endmodule

// File: rtl/syscfg_fall.sv
module syscfg_fall (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic pulse
);
   logic prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;
   end
   assign pulse = prev & ~level;
endmodule

// File: rtl/syscfg_regs.sv
module syscfg_regs #(
   parameter int                 DATA_W      = 32,
   parameter int                 ADDR_W      = 4,
   parameter logic [DATA_W-1:0]  DEVCFG_DFLT = '0,
   parameter int                 SWRST_BIT   = 31,
   parameter int                 SSP_BIT     = 6,
   parameter int                 AC97_BIT    = 7,
   parameter int                 REV_LSB     = 28,
   parameter int                 REV_W       = 4,
   parameter int                 REV_VAL     = 5,
   parameter logic [DATA_W-1:0]  SYSID_BASE  = '0,
   parameter bit                 EXCL_ROUTE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] devcfg_o,
   output logic [DATA_W-1:0] auddiv_o,
   output logic              rst_req_o,
   output logic              route_ssp_o,
   output logic              route_ac97_o
);
   import syscfg_pkg::*;

   localparam logic [DATA_W-1:0] REV_MASK   = DATA_W'((64'd1 << REV_W) - 64'd1) << REV_LSB;
   localparam logic [DATA_W-1:0] REV_FIELD  = (DATA_W'(REV_VAL) << REV_LSB) & REV_MASK;
   localparam logic [DATA_W-1:0] SYSID_WORD = (SYSID_BASE & ~REV_MASK) | REV_FIELD;
   localparam logic [NPROT-1:0][DATA_W-1:0] PROT_RST = {DATA_W'(0), DEVCFG_DFLT};
   localparam logic [NPROT-1:0][ADDR_W-1:0] PROT_IDX =
      {ADDR_W'(IDX_AUDDIV), ADDR_W'(IDX_DEVCFG)};

   // elaboration-time parameter checks
   if (DATA_W < 8)                    begin : g_bad_width $error("DATA_W must hold the key byte"); end
   if (ADDR_W < 2)                    begin : g_bad_addr  $error("ADDR_W too small for four words"); end
   if (SWRST_BIT >= DATA_W)           begin : g_bad_rst   $error("SWRST_BIT outside word"); end
   if (SSP_BIT >= DATA_W || AC97_BIT >= DATA_W || SSP_BIT == AC97_BIT)
                                      begin : g_bad_route $error("route bits invalid"); end
   if (REV_W < 1 || REV_LSB + REV_W > DATA_W)
                                      begin : g_bad_rev   $error("revision field outside word"); end

   logic armed;
   logic key_hit;
   logic [NPROT-1:0][DATA_W-1:0] prot_q;

   assign key_hit = bus_we && (bus_addr == ADDR_W'(IDX_LOCK)) &&
                    (bus_wdata[7:0] == UNLOCK_KEY);

   syscfg_lock u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_we  (bus_we),
      .key_hit (key_hit),
      .armed   (armed)
   );

   for (genvar i = 0; i < NPROT; i++) begin : g_prot
      logic wr_en;
      assign wr_en = bus_we && armed && (bus_addr == PROT_IDX[i]);
      syscfg_preg #(.W(DATA_W), .RST(PROT_RST[i])) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr_en),
         .wdata (bus_wdata),
         .q     (prot_q[i])
      );
   end

   assign devcfg_o = prot_q[PSEL_DEVCFG];
   assign auddiv_o = prot_q[PSEL_AUDDIV];

   syscfg_fall u_swrst (
      .clk   (clk),
      .rst_n (rst_n),
      .level (devcfg_o[SWRST_BIT]),
      .pulse (rst_req_o)
   );

   logic want_ssp, want_ac97;
   assign want_ssp  = devcfg_o[SSP_BIT];
   assign want_ac97 = devcfg_o[AC97_BIT];

   if (EXCL_ROUTE) begin : g_route_excl
      assign route_ssp_o  = want_ssp  & ~want_ac97;
      assign route_ac97_o = want_ac97 & ~want_ssp;
   end else begin : g_route_prio
      assign route_ssp_o  = want_ssp;
      assign route_ac97_o = want_ac97 & ~want_ssp;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(IDX_LOCK))        bus_rdata = DATA_W'(armed);
      else if (bus_addr == ADDR_W'(IDX_DEVCFG)) bus_rdata = devcfg_o;
      else if (bus_addr == ADDR_W'(IDX_AUDDIV)) bus_rdata = auddiv_o;
      else if (bus_addr == ADDR_W'(IDX_SYSID))  bus_rdata = SYSID_WORD;
   end
endmodule

// File: rtl/syscfg_regs_chk.sv
module syscfg_regs_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] devcfg_o,
   input logic [DATA_W-1:0] auddiv_o,
   input logic              rst_req_o,
   input logic              route_ssp_o,
   input logic              route_ac97_o,
   input logic              armed
);
   import syscfg_pkg::*;

   logic is_key;
   assign is_key = bus_we && bus_addr == ADDR_W'(IDX_LOCK) && bus_wdata[7:0] == UNLOCK_KEY;

   a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
      is_key |=> armed);

   a_r2_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(IDX_LOCK)) |-> (bus_rdata == DATA_W'(armed)));

   a_r5_any_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !is_key) |=> !armed);

   a_r3_armed_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && armed && bus_addr == ADDR_W'(IDX_DEVCFG)) |=> (devcfg_o == $past(bus_wdata)));

   a_r4_devcfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !armed && bus_addr == ADDR_W'(IDX_DEVCFG)) |=> $stable(devcfg_o));

   a_r4_auddiv_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !armed && bus_addr == ADDR_W'(IDX_AUDDIV)) |=> $stable(auddiv_o));

   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   a_r8_routes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(route_ssp_o && route_ac97_o));
endmodule

bind syscfg_regs syscfg_regs_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .devcfg_o     (devcfg_o),
   .auddiv_o     (auddiv_o),
   .rst_req_o    (rst_req_o),
   .route_ssp_o  (route_ssp_o),
   .route_ac97_o (route_ac97_o),
   .armed        (armed)
);

// File: tb/syscfg_regs_bench.sv
`timescale 1ns/1ps
module syscfg_regs_bench;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata, devcfg_o, auddiv_o;
   logic          rst_req_o, route_ssp_o, route_ac97_o;

   always #2.5 clk = ~clk;

   syscfg_regs u_syscfg_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .devcfg_o(devcfg_o),
      .auddiv_o(auddiv_o), .rst_req_o(rst_req_o), .route_ssp_o(route_ssp_o),
      .route_ac97_o(route_ac97_o)
   );

   typedef struct {
      string         req;
      logic [DW-1:0] val;
   } exp_t;

   exp_t exp_q[$];
   bit   chk_pending = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   int   pulses = 0;
   bit   done = 0;

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops expected read results and compares them with the bus
   always @(negedge clk) begin
      #1;
      if (chk_pending && exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         check(it.req, bus_rdata, it.val);
      end
   end

   always @(negedge clk) if (rst_n && rst_req_o) pulses++;

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [DW-1:0] e, input string req);
      exp_t it;
      @(negedge clk);
      bus_addr = AW'(a);
      it.req = req; it.val = e;
      exp_q.push_back(it);
      chk_pending = 1;
      @(negedge clk);
      chk_pending = 0;
   endtask

   task automatic out(input string req, input logic [DW-1:0] act, input logic [DW-1:0] e);
      @(negedge clk); #1;
      check(req, act, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, 0, "R1 lock");
      rd(1, 0, "R1 devcfg");
      rd(2, 0, "R1 auddiv");
      out("R1 rst_req", DW'(rst_req_o), 0);
      // R4 unarmed write ignored
      wr(1, 32'h0000_1234);
      rd(1, 0, "R4 devcfg unarmed");
      // R2 key arms, read shows 1
      wr(0, 32'h0000_00AA);
      rd(0, 1, "R2 lock armed");
      // R3 armed write
      wr(1, 32'h0000_0040);
      rd(1, 32'h0000_0040, "R3 devcfg");
      rd(0, 0, "R5 lock after write");
      out("R9 devcfg_o", devcfg_o, 32'h0000_0040);
      out("R8 ssp route", {route_ac97_o, route_ssp_o}, 2'b01);
      // R5 one-shot
      wr(1, 32'h0000_00FF);
      rd(1, 32'h0000_0040, "R5 second write blocked");
      wr(0, 32'h0000_00AA);
      wr(2, 32'h0000_ABCD);
      rd(2, 32'h0000_ABCD, "R3 auddiv");
      out("R9 auddiv_o", auddiv_o, 32'h0000_ABCD);
      wr(2, 32'h0000_1111);
      rd(2, 32'h0000_ABCD, "R4 auddiv unarmed");
      // R6 read-only id word consumes the key
      wr(0, 32'h0000_00AA);
      wr(3, 32'hFFFF_FFFF);
      rd(3, 32'h5000_0000, "R6 sysid unchanged");
      rd(0, 0, "R5 disarmed by sysid write");
      wr(1, 32'h0000_0001);
      rd(1, 32'h0000_0040, "R5 devcfg after sysid write");
      // R5 non-key lock write disarms
      wr(0, 32'h0000_00AA);
      wr(0, 32'h0000_0055);
      rd(0, 0, "R5 non-key lock write");
      // R5 unmapped write disarms
      wr(0, 32'h0000_00AA);
      wr(9, 32'h0000_0000);
      wr(1, 32'h0000_0002);
      rd(1, 32'h0000_0040, "R5 unmapped write disarms");
      // R8 both route bits, then ac97 only
      wr(0, 32'h0000_00AA);
      wr(1, 32'h0000_00C0);
      out("R8 both requested", {route_ac97_o, route_ssp_o}, 2'b00);
      wr(0, 32'h0000_00AA);
      wr(1, 32'h0000_0080);
      out("R8 ac97 route", {route_ac97_o, route_ssp_o}, 2'b10);
      // R7 set then clear software reset
      pulses = 0;
      wr(0, 32'h0000_00AA);
      wr(1, 32'h8000_0080);
      repeat (2) @(negedge clk);
      check("R7 no pulse on set", DW'(pulses), 0);
      wr(0, 32'h0000_00AA);
      wr(1, 32'h0000_0080);
      repeat (3) @(negedge clk);
      check("R7 one pulse on clear", DW'(pulses), 1);
      // R10 unmapped read, R6 revision by mask and shift
      rd(5, 0, "R10 unmapped");
      @(negedge clk);
      bus_addr = AW'(3);
      #1;
      check("R6 revision field", (bus_rdata >> 28) & 32'hF, 5);
      repeat (2) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule